// File: doc/BRIEF.md
# Multiplexed-Address Programmer Port Front End

This block sits between the parallel programming pins of a 256K x 8 flash-style memory and its storage array. A strap input decides, at reset time only, whether the part answers on the parallel programmer port or leaves the pins to a separate serial host interface. The decision is held until the next reset.

In programmer mode the 18-bit byte address is built from two halves that share one 11-bit address bus. A row/column select input tells the block which half is on the bus. The row half supplies the low 11 address bits and the column half supplies the upper 7. Read data from the array goes to the data pins only while the output enable is asserted. A write strobe turns the data pins into a write to the array at the assembled address. During reset, and at all times in serial mode, the port drives nothing.

All inputs are sampled on the rising edge of `clk`. The address registers change at that edge. Output enables and write requests follow the current control inputs combinationally through the held mode.

Top module: `mux_addr_pgm_port`

## Requirements
- R1: If `modeStrap` is 1 on the last clock edge with `rstN` low, `modeIsProgrammer` is 1 after reset release. If it is 0 there, `modeIsProgrammer` is 0.
- R2: While `rstN` is high, changes on `modeStrap` have no effect on `modeIsProgrammer`.
- R3: In programmer mode, on a clock edge where `rowColSel` is sampled 0 and was sampled 1 at the previous edge, `addrIn[10:0]` is loaded into `memAddr[10:0]`. At all other edges, `memAddr[10:0]` holds.
- R4: In programmer mode, on every clock edge where `rowColSel` is sampled 1, `addrIn[6:0]` is loaded into `memAddr[17:11]`. `addrIn[10:7]` has no effect on the column half.
- R5: `dqOe` is 1 exactly when the port is in programmer mode, `rstN` is 1, `oeN` is 0 and `weN` is 1. `dqOut` always equals `memRdData`.
- R6: `memWrEn` is 1 exactly when the port is in programmer mode, `rstN` is 1 and `weN` is 0. `memWrData` equals `dqIn`.
- R7: When `oeN` and `weN` are both 0, the write is issued and `dqOe` stays 0.
- R8: While `rstN` is 0, `dqOe` and `memWrEn` are 0, and `memAddr` is 0 from the first clock edge in reset onwards.
- R9: In serial mode, `dqOe` and `memWrEn` stay 0 and `memAddr` keeps its reset value of 0 whatever `rowColSel` and `addrIn` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low reset; mode strap captured while low |
| modeStrap | input | 1 | 1 = programmer mode, 0 = serial host mode |
| rowColSel | input | 1 | 1 = column half on bus, falling edge loads row half |
| addrIn | input | 11 | Shared row/column address bus |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write enable |
| dqIn | input | 8 | Data from the pins |
| dqOut | output | 8 | Data to the pins |
| dqOe | output | 1 | Data pin driver enable, 0 = high impedance |
| memAddr | output | 18 | Assembled byte address to the array |
| memWrEn | output | 1 | Array write request |
| memWrData | output | 8 | Array write data |
| memRdData | input | 8 | Array read data |
| modeIsProgrammer | output | 1 | Latched interface mode |

## Verification
The bench toggles the strap after reset release. A design that kept sampling the strap would then change mode in the middle of operation. It holds the select high for several cycles and checks that the row half loads only on the falling edge. A design that loads it on the level would corrupt the low address bits. It drives both enables low together, where a wrong priority would drive the bus while the array is being written. It also runs a reset in serial mode with busy address traffic, where a leaky design would load addresses or enable the drivers.

// File: rtl/pgm_port_pkg.sv
package pgm_port_pkg;
  parameter int ROW_W  = 11;
  parameter int COL_W  = 7;
  parameter int DATA_W = 8;
  localparam int ADDR_W = ROW_W + COL_W;

  typedef struct packed {
    logic clearAddr;
    logic loadRow;
    logic loadCol;
    logic driveBus;
    logic writeBus;
  } pgmStrobes_t;
endpackage

// File: rtl/pgm_port_ctrl.sv
module pgm_port_ctrl
  import pgm_port_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeStrap,
  input  logic        rowColSel,
  input  logic        oeN,
  input  logic        weN,
  output pgmStrobes_t strb,
  output logic        modeIsProgrammer
);
  logic modeReg;
  logic selPrev;

  // Strap captured only while reset is held; frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rstN) modeReg <= modeStrap;
  end

  // Select history kept through reset so the first edge after release is seen.
  always_ff @(posedge clk) begin
    selPrev <= rowColSel;
  end

  logic active;
  assign active = rstN && modeReg;

  always_comb begin
    strb.clearAddr = !rstN;
    strb.loadRow   = active && selPrev && !rowColSel;
    strb.loadCol   = active && rowColSel;
    strb.writeBus  = active && !weN;
    strb.driveBus  = active && !oeN && weN;
  end

  assign modeIsProgrammer = modeReg;

  // R2: mode frozen while out of reset
  a_r2_mode_frozen: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(modeIsProgrammer));

  // R7: write beats output enable
  a_r7_write_priority: assert property (@(posedge clk) disable iff (!rstN)
    (modeIsProgrammer && !weN && !oeN) |-> (strb.writeBus && !strb.driveBus));

  // R9: serial mode keeps programmer port quiet
  a_r9_serial_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !modeIsProgrammer |-> !(strb.driveBus || strb.writeBus || strb.loadRow || strb.loadCol));
endmodule

// File: rtl/pgm_port_dp.sv
module pgm_port_dp
  import pgm_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pgmStrobes_t       strb,
  input  logic [ROW_W-1:0]  addrIn,
  input  logic [DATA_W-1:0] dqIn,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe
);
  logic [ROW_W-1:0] rowReg;
  logic [COL_W-1:0] colReg;

  always_ff @(posedge clk) begin
    if (strb.clearAddr) begin
      rowReg <= '0;
      colReg <= '0;
    end else begin
      if (strb.loadRow) rowReg <= addrIn;
      if (strb.loadCol) colReg <= addrIn[COL_W-1:0];
    end
  end

  assign memAddr   = {colReg, rowReg};
  assign memWrEn   = strb.writeBus;
  assign memWrData = dqIn;
  assign dqOut     = memRdData;
  assign dqOe      = strb.driveBus;

  // R8: nothing driven or written during reset
  a_r8_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (!dqOe && !memWrEn));

  // R3: row half follows bus after a load strobe
  a_r3_row_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadRow |=> (memAddr[ROW_W-1:0] == $past(addrIn)));

  // R4: column half follows low bus bits after a load strobe
  a_r4_col_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCol |=> (memAddr[ADDR_W-1:ROW_W] == $past(addrIn[COL_W-1:0])));

  // R3: row half holds without a load strobe
  a_r3_row_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadRow && $past(rstN)) |=> $stable(memAddr[ROW_W-1:0]));
endmodule

// File: rtl/mux_addr_pgm_port.sv
module mux_addr_pgm_port
  import pgm_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeStrap,
  input  logic              rowColSel,
  input  logic [ROW_W-1:0]  addrIn,
  input  logic              oeN,
  input  logic              weN,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              modeIsProgrammer
);
  pgmStrobes_t strb;

  pgm_port_ctrl ctrl_i (
    .clk              (clk),
    .rstN             (rstN),
    .modeStrap        (modeStrap),
    .rowColSel        (rowColSel),
    .oeN              (oeN),
    .weN              (weN),
    .strb             (strb),
    .modeIsProgrammer (modeIsProgrammer)
  );

  pgm_port_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .addrIn    (addrIn),
    .dqIn      (dqIn),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memWrEn   (memWrEn),
    .memWrData (memWrData),
    .dqOut     (dqOut),
    .dqOe      (dqOe)
  );
endmodule

// File: tb/mux_addr_pgm_port_tb.sv
`timescale 1ns/1ps
module mux_addr_pgm_port_tb_top;
  logic        clk = 0;
  logic        rstN = 0;
  logic        modeStrap = 1;
  logic        rowColSel = 0;
  logic [10:0] addrIn = 0;
  logic        oeN = 1, weN = 1;
  logic [7:0]  dqIn = 0, memRdData = 0;
  logic [7:0]  dqOut, memWrData;
  logic        dqOe, memWrEn, modeIsProgrammer;
  logic [17:0] memAddr;

  int nChecks = 0, nFail = 0;
  bit compareOn = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mux_addr_pgm_port dut_i (
    .clk(clk), .rstN(rstN), .modeStrap(modeStrap), .rowColSel(rowColSel),
    .addrIn(addrIn), .oeN(oeN), .weN(weN), .dqIn(dqIn), .dqOut(dqOut),
    .dqOe(dqOe), .memAddr(memAddr), .memWrEn(memWrEn), .memWrData(memWrData),
    .memRdData(memRdData), .modeIsProgrammer(modeIsProgrammer)
  );

  // Behavioural reference state
  bit         mMode;
  bit         mPrevSel;
  int         mRow, mCol;

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = modeStrap; mRow = 0; mCol = 0;
    end else if (mMode) begin
      if (mPrevSel && !rowColSel) mRow = addrIn;
      if (rowColSel) mCol = addrIn % 128;
    end
    mPrevSel = rowColSel;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (compareOn) begin
      bit live;
      bit expOe, expWr;
      live  = rstN && mMode;
      expWr = live && !weN;
      expOe = live && !oeN && weN;
      check(modeIsProgrammer == mMode, "R1/R2 mode", modeIsProgrammer, mMode);
      check(memAddr == ((mCol << 11) | mRow), "R3/R4/R8/R9 address", memAddr, (mCol << 11) | mRow);
      check(dqOe == expOe, "R5/R7/R8/R9 dqOe", dqOe, expOe);
      check(memWrEn == expWr, "R6/R7/R8/R9 memWrEn", memWrEn, expWr);
      check(dqOut == memRdData, "R5 dqOut", dqOut, memRdData);
      check(memWrData == dqIn, "R6 memWrData", memWrData, dqIn);
    end
  end

  task automatic step(input bit sel, input int a, input bit o, input bit w);
    @(negedge clk);
    rowColSel = sel; addrIn = a[10:0]; oeN = o; weN = w;
    dqIn = $urandom; memRdData = $urandom;
  endtask

  initial begin
    // R1: reset with strap high -> programmer mode
    modeStrap = 1; rstN = 0;
    repeat (3) @(negedge clk);
    compareOn = 1;
    check(dqOe == 0 && memWrEn == 0 && memAddr == 0, "R8 reset state", {dqOe, memWrEn}, 0);
    @(negedge clk) rstN = 1;
    @(negedge clk);
    check(modeIsProgrammer == 1, "R1 programmer after release", modeIsProgrammer, 1);
    // R2: strap toggles after release are ignored
    modeStrap = 0;
    repeat (3) @(negedge clk);
    check(modeIsProgrammer == 1, "R2 strap ignored", modeIsProgrammer, 1);

    // R4 then R3: column phase with upper bits set, then row on falling edge
    step(1, 11'h7A5, 1, 1);   // col = 0x25, A[10:7] ignored
    step(1, 11'h6A5, 1, 1);   // held high: row must not load (R3)
    step(0, 11'h123, 1, 1);   // falling edge loads row
    step(0, 11'h456, 1, 1);   // level low: no reload
    @(negedge clk);
    check(memAddr == {7'h25, 11'h123}, "R3/R4 assembled address", memAddr, {7'h25, 11'h123});

    // R5 read, R6 write, R7 both low
    step(0, 0, 0, 1);
    @(negedge clk);
    check(dqOe == 1, "R5 read enables bus", dqOe, 1);
    step(0, 0, 1, 0);
    @(negedge clk);
    check(memWrEn == 1 && dqOe == 0, "R6 write strobe", {memWrEn, dqOe}, 2'b10);
    step(0, 0, 0, 0);
    @(negedge clk);
    check(memWrEn == 1 && dqOe == 0, "R7 write priority", {memWrEn, dqOe}, 2'b10);

    // Random traffic in programmer mode
    for (int i = 0; i < 600; i++) begin
      step($urandom_range(0, 1), $urandom, $urandom_range(0, 1), $urandom_range(0, 1));
      if (i % 97 == 0) modeStrap = $urandom;
    end

    // R8: reset mid-run with bus activity
    @(negedge clk) rstN = 0; modeStrap = 0;
    for (int i = 0; i < 5; i++) step($urandom_range(0, 1), $urandom, 0, 0);
    check(memAddr == 0 && dqOe == 0 && memWrEn == 0, "R8 halted in reset", memAddr, 0);
    @(negedge clk) rstN = 1;
    @(negedge clk);
    check(modeIsProgrammer == 0, "R1 serial after release", modeIsProgrammer, 0);

    // R9: serial mode ignores everything
    modeStrap = 1;
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 1), $urandom, $urandom_range(0, 1), $urandom_range(0, 1));
    step(1, 11'h7FF, 0, 1);
    step(0, 11'h7FF, 0, 0);
    @(negedge clk);
    check(memAddr == 0 && dqOe == 0 && memWrEn == 0, "R9 serial quiet", memAddr, 0);

    // Back to programmer mode: strap sampled on last reset edge
    @(negedge clk) rstN = 0; modeStrap = 0;
    @(negedge clk) modeStrap = 1;
    @(negedge clk) rstN = 1;
    @(negedge clk);
    check(modeIsProgrammer == 1, "R1 last reset sample wins", modeIsProgrammer, 1);
    for (int i = 0; i < 300; i++)
      step($urandom_range(0, 1), $urandom, $urandom_range(0, 1), $urandom_range(0, 1));

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nChecks++; nFail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule